// File: doc/BRIEF.md
# Ready-Latency Packet Source

This block sits on the client side of a wide transmit streaming port and acts as its data source. Packet words are written into an internal store-and-forward buffer through a simple write port, one word per cycle. A packet is released toward the sink only after its last word has been written, so once the first word leaves, the rest follow on every ready cycle without idle gaps.

The sink signals readiness with a ready input whose meaning is shifted in time by a fixed latency. Ready seen high on cycle n makes cycle n + READY_LAT a ready cycle. A word is transferred only on a ready cycle while valid is high. Inside a packet, valid stays high and the presented word is held unchanged through any cycle that is not a ready cycle. No packet is started while the link-stable input is low. Along with each end-of-packet word the block presents an empty-byte count and an error flag. A skip-CRC flag is captured from the first word and held for the whole packet.

Top module: `pkt_streamer`

## Requirements
- R1: A cycle is a ready cycle only if `tx_ready` was high exactly READY_LAT cycles before (same cycle when READY_LAT is 0). A word transfers only when `tx_valid` is high on a ready cycle, and `tx_sop` is raised only on a ready cycle. After ready falls, transfers continue for exactly READY_LAT cycles and then stop.
- R2: `tx_sop` is never asserted while `link_stable` is low. Packets written while the link is not stable are held until it rises.
- R3: From the start-of-packet word through the end-of-packet word, `tx_valid` stays high, and every ready cycle in that span transfers a word. No idle gap falls inside a packet.
- R4: When `tx_valid` is high on a cycle that is not a ready cycle, the next cycle presents the same `tx_data`, `tx_eop`, `tx_empty` and `tx_error`.
- R5: Each packet shows `tx_sop` on exactly one transfer (its first word) and `tx_eop` on exactly one transfer (its last word). A single-word packet has both on the same transfer. Neither is ever high while `tx_valid` is low.
- R6: `tx_empty` and `tx_error` carry the values written with the end-of-packet word, and both read zero on every other word. `tx_empty` is the number of unused bytes, counted from the least significant end.
- R7: `tx_skip_crc` equals the value written with the packet's first word, on every word of that packet.
- R8: A packet does not start until its end-of-packet word has been written into the buffer.
- R9: Words leave in write order with their data unchanged. The first byte of the packet is in `tx_data[DATA_W-1 -: 8]`, and bit 0 is the least significant bit.
- R10: `wr_ready` is low exactly when the buffer holds DEPTH words. A write presented while `wr_ready` is low is dropped and never appears at the output. DEPTH must be at least the largest packet in words.
- R11: After reset, `tx_valid` and `tx_sop` are low, `wr_ready` is high and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| link_stable | input | 1 | High when the link can carry packets |
| wr_valid | input | 1 | Write strobe for one buffer word |
| wr_data | input | DATA_W | Word to buffer; first packet byte in the top lane |
| wr_eop | input | 1 | Marks the written word as the last of its packet |
| wr_empty | input | EMPTY_W | Unused bytes in the last word |
| wr_error | input | 1 | Request to mark the packet bad, taken from the last word |
| wr_skip_crc | input | 1 | Skip-CRC request, taken from the first word |
| wr_ready | output | 1 | Buffer has room for a word |
| tx_ready | input | 1 | Sink readiness, effective READY_LAT cycles later |
| tx_valid | output | 1 | Word on the bus is valid |
| tx_data | output | DATA_W | Outgoing packet word |
| tx_sop | output | 1 | First word of a packet |
| tx_eop | output | 1 | Last word of a packet |
| tx_empty | output | EMPTY_W | Unused bytes on the last word, else zero |
| tx_error | output | 1 | Packet error flag on the last word |
| tx_skip_crc | output | 1 | Skip-CRC flag held across the packet |

## Verification
A fault in the ready history shows as a word advancing on a cycle that should hold it, or as an idle ready cycle inside a packet. Either is visible within READY_LAT + 1 cycles of a ready change. If the packet count drifts, a packet starts before its last word is written, or buffered packets stall forever. Premature starts appear on the first ready cycle after the early start. A stuck count shows up when a drain does not finish. Pointer or occupancy faults surface as reordered or duplicated words, or as `wr_ready` disagreeing with the number of words written minus words sent, on the cycle the buffer reaches full.

// File: rtl/pkt_streamer_pkg.sv
package pkt_streamer_pkg;

    // Per-word sideband kept next to the data in the buffer
    typedef struct packed {
        logic eop;
        logic err;
        logic skip;
    } ps_side_t;

    typedef enum logic [0:0] {
        PS_IDLE  = 1'b0,
        PS_BURST = 1'b1
    } ps_state_t;

    // Circular pointer increment for any depth
    function automatic int unsigned ps_wrap_inc(input int unsigned p, input int unsigned depth);
        return (p + 1 == depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/ps_ready_pipe.sv
module ps_ready_pipe #(
    parameter int READY_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ready,
    output logic allow
);
    // stage[k] holds the ready value seen k cycles ago
    logic stage [READY_LAT+1];

    always_comb stage[0] = ready;

    for (genvar k = 1; k <= READY_LAT; k++) begin : g_hist
        always_ff @(posedge clk) begin
            if (rst) stage[k] <= 1'b0;
            else     stage[k] <= stage[k-1];
        end
    end

    assign allow = stage[READY_LAT];
endmodule

// File: rtl/ps_word_fifo.sv
module ps_word_fifo
    import pkt_streamer_pkg::*;
#(
    parameter int DATA_W  = 512,
    parameter int EMPTY_W = 6,
    parameter int DEPTH   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push,
    input  logic [DATA_W-1:0]  push_data,
    input  logic [EMPTY_W-1:0] push_empty,
    input  ps_side_t           push_side,
    input  logic               pop,
    output logic [DATA_W-1:0]  head_data,
    output logic [EMPTY_W-1:0] head_empty,
    output ps_side_t           head_side,
    output logic               full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0]  data_mem  [DEPTH];
    logic [EMPTY_W-1:0] empty_mem [DEPTH];
    ps_side_t           side_mem  [DEPTH];

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] used;

    always_ff @(posedge clk) begin
        if (push) begin
            data_mem[wr_ptr]  <= push_data;
            empty_mem[wr_ptr] <= push_empty;
            side_mem[wr_ptr]  <= push_side;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
        end else begin
            if (push) wr_ptr <= PTR_W'(ps_wrap_inc(32'(wr_ptr), DEPTH));
            if (pop)  rd_ptr <= PTR_W'(ps_wrap_inc(32'(rd_ptr), DEPTH));
            case ({push, pop})
                2'b10:   used <= used + CNT_W'(1);
                2'b01:   used <= used - CNT_W'(1);
                default: used <= used;
            endcase
        end
    end

    assign head_data  = data_mem[rd_ptr];
    assign head_empty = empty_mem[rd_ptr];
    assign head_side  = side_mem[rd_ptr];
    assign full       = (used == CNT_W'(DEPTH));
endmodule

// File: rtl/ps_pkt_count.sv
module ps_pkt_count #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic has_pkt
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] pkts;

    always_ff @(posedge clk) begin
        if (rst) begin
            pkts <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   pkts <= pkts + CNT_W'(1);
                2'b01:   pkts <= pkts - CNT_W'(1);
                default: pkts <= pkts;
            endcase
        end
    end

    assign has_pkt = (pkts != '0);
endmodule

// File: rtl/ps_tx_ctrl.sv
module ps_tx_ctrl
    import pkt_streamer_pkg::*;
#(
    parameter int EMPTY_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               allow,
    input  logic               link_ok,
    input  logic               has_pkt,
    input  ps_side_t           head_side,
    input  logic [EMPTY_W-1:0] head_empty,
    output logic               valid,
    output logic               sop,
    output logic               eop,
    output logic [EMPTY_W-1:0] empty,
    output logic               err,
    output logic               skip,
    output logic               pop,
    output logic               pkt_done
);
    ps_state_t state;
    logic      skip_q;
    logic      start;
    logic      xfer;

    // A new packet begins only on a ready cycle with a whole packet buffered
    assign start    = (state == PS_IDLE) && has_pkt && link_ok && allow;
    assign valid    = start || (state == PS_BURST);
    assign xfer     = valid && allow;
    assign pop      = xfer;
    assign pkt_done = xfer && head_side.eop;

    assign sop   = start;
    assign eop   = valid && head_side.eop;
    assign empty = eop ? head_empty : '0;
    assign err   = eop && head_side.err;
    assign skip  = start ? head_side.skip : ((state == PS_BURST) && skip_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PS_IDLE;
            skip_q <= 1'b0;
        end else begin
            if (start) skip_q <= head_side.skip;
            case (state)
                PS_IDLE:  if (start && !head_side.eop) state <= PS_BURST;
                PS_BURST: if (pkt_done)                state <= PS_IDLE;
                default:                               state <= PS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pkt_streamer.sv
module pkt_streamer
    import pkt_streamer_pkg::*;
#(
    parameter int DATA_W    = 512,
    parameter int EMPTY_W   = $clog2(DATA_W / 8),
    parameter int DEPTH     = 16,
    parameter int READY_LAT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               link_stable,
    input  logic               wr_valid,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               wr_eop,
    input  logic [EMPTY_W-1:0] wr_empty,
    input  logic               wr_error,
    input  logic               wr_skip_crc,
    output logic               wr_ready,
    input  logic               tx_ready,
    output logic               tx_valid,
    output logic [DATA_W-1:0]  tx_data,
    output logic               tx_sop,
    output logic               tx_eop,
    output logic [EMPTY_W-1:0] tx_empty,
    output logic               tx_error,
    output logic               tx_skip_crc
);
    logic               full;
    logic               push;
    logic               pop;
    logic               allow;
    logic               has_pkt;
    logic               pkt_done;
    ps_side_t           side_in;
    ps_side_t           head_side;
    logic [EMPTY_W-1:0] head_empty;

    assign wr_ready = !full;
    assign push     = wr_valid && !full;
    assign side_in  = '{eop: wr_eop, err: wr_error, skip: wr_skip_crc};

    ps_ready_pipe #(.READY_LAT(READY_LAT)) u_rdy (
        .clk   (clk),
        .rst   (rst),
        .ready (tx_ready),
        .allow (allow)
    );

    ps_word_fifo #(.DATA_W(DATA_W), .EMPTY_W(EMPTY_W), .DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_data  (wr_data),
        .push_empty (wr_empty),
        .push_side  (side_in),
        .pop        (pop),
        .head_data  (tx_data),
        .head_empty (head_empty),
        .head_side  (head_side),
        .full       (full)
    );

    ps_pkt_count #(.DEPTH(DEPTH)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (push && wr_eop),
        .dec     (pkt_done),
        .has_pkt (has_pkt)
    );

    ps_tx_ctrl #(.EMPTY_W(EMPTY_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .allow      (allow),
        .link_ok    (link_stable),
        .has_pkt    (has_pkt),
        .head_side  (head_side),
        .head_empty (head_empty),
        .valid      (tx_valid),
        .sop        (tx_sop),
        .eop        (tx_eop),
        .empty      (tx_empty),
        .err        (tx_error),
        .skip       (tx_skip_crc),
        .pop        (pop),
        .pkt_done   (pkt_done)
    );
endmodule

// File: rtl/pkt_streamer_chk.sv
module pkt_streamer_chk #(
    parameter int DATA_W    = 512,
    parameter int EMPTY_W   = 6,
    parameter int DEPTH     = 16,
    parameter int READY_LAT = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               link_stable,
    input logic               wr_valid,
    input logic               wr_eop,
    input logic               wr_ready,
    input logic               tx_ready,
    input logic               tx_valid,
    input logic [DATA_W-1:0]  tx_data,
    input logic               tx_sop,
    input logic               tx_eop,
    input logic [EMPTY_W-1:0] tx_empty,
    input logic               tx_error,
    input logic               tx_skip_crc
);
    localparam int OCC_W = $clog2(DEPTH + 1) + 1;

    // Independent ready history rebuilt from the port
    logic hist [READY_LAT+1];
    always_comb hist[0] = tx_ready;
    for (genvar k = 1; k <= READY_LAT; k++) begin : g_h
        always_ff @(posedge clk) begin
            if (rst) hist[k] <= 1'b0;
            else     hist[k] <= hist[k-1];
        end
    end

    logic             rdy_cyc;
    logic             moved;
    logic             wrote;
    logic             in_pkt;
    logic             skip_ref;
    logic [OCC_W-1:0] occ;
    logic [OCC_W-1:0] pkts;

    assign rdy_cyc = hist[READY_LAT];
    assign moved   = tx_valid && rdy_cyc;
    assign wrote   = wr_valid && wr_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt   <= 1'b0;
            skip_ref <= 1'b0;
            occ      <= '0;
            pkts     <= '0;
        end else begin
            if (moved && tx_sop) begin
                in_pkt   <= !tx_eop;
                skip_ref <= tx_skip_crc;
            end else if (moved && tx_eop) begin
                in_pkt <= 1'b0;
            end
            occ  <= occ + OCC_W'(wrote) - OCC_W'(moved);
            pkts <= pkts + OCC_W'(wrote && wr_eop) - OCC_W'(moved && tx_eop);
        end
    end

    assert_sop_on_ready_R1: assert property (@(posedge clk) disable iff (rst)
        tx_sop |-> rdy_cyc);

    assert_link_gate_R2: assert property (@(posedge clk) disable iff (rst)
        tx_sop |-> link_stable);

    assert_no_gap_R3: assert property (@(posedge clk) disable iff (rst)
        in_pkt |-> tx_valid);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !rdy_cyc) |=> ($stable(tx_data) && $stable(tx_eop)
                                    && $stable(tx_empty) && $stable(tx_error)));

    assert_single_sop_R5: assert property (@(posedge clk) disable iff (rst)
        tx_sop |-> (tx_valid && !in_pkt));

    assert_eop_valid_R5: assert property (@(posedge clk) disable iff (rst)
        tx_eop |-> tx_valid);

    assert_tail_only_R6: assert property (@(posedge clk) disable iff (rst)
        !tx_eop |-> (tx_empty == '0 && !tx_error));

    assert_skip_const_R7: assert property (@(posedge clk) disable iff (rst)
        in_pkt |-> (tx_skip_crc == skip_ref));

    assert_whole_pkt_R8: assert property (@(posedge clk) disable iff (rst)
        tx_sop |-> (pkts != '0));

    assert_full_flag_R10: assert property (@(posedge clk) disable iff (rst)
        wr_ready == (occ < OCC_W'(DEPTH)));
endmodule

bind pkt_streamer pkt_streamer_chk #(
    .DATA_W(DATA_W), .EMPTY_W(EMPTY_W), .DEPTH(DEPTH), .READY_LAT(READY_LAT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .link_stable (link_stable),
    .wr_valid    (wr_valid),
    .wr_eop      (wr_eop),
    .wr_ready    (wr_ready),
    .tx_ready    (tx_ready),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_sop      (tx_sop),
    .tx_eop      (tx_eop),
    .tx_empty    (tx_empty),
    .tx_error    (tx_error),
    .tx_skip_crc (tx_skip_crc)
);

// File: tb/sim_pkt_streamer.sv
module sim_pkt_streamer;
    localparam int DW  = 512;
    localparam int EW  = 6;
    localparam int DEP = 16;
    localparam int LAT = 2;
    localparam int NV  = 6;

    // Vector fields: [3:0] words, [9:4] empty, [10] error, [11] skip, [31:16] ready pattern
    localparam logic [31:0] VEC [NV] = '{
        {16'hFFFF, 4'h0, 1'b1, 1'b0, 6'd5,  4'd1},
        {16'hAAAA, 4'h0, 1'b0, 1'b1, 6'd0,  4'd4},
        {16'hF0F0, 4'h0, 1'b1, 1'b0, 6'd63, 4'd8},
        {16'h8421, 4'h0, 1'b1, 1'b1, 6'd17, 4'd3},
        {16'hFFFE, 4'h0, 1'b0, 1'b0, 6'd1,  4'd2},
        {16'h3333, 4'h0, 1'b0, 1'b0, 6'd40, 4'd6}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          link_stable = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_eop = 1'b0;
    logic [EW-1:0] wr_empty = '0;
    logic          wr_error = 1'b0;
    logic          wr_skip_crc = 1'b0;
    logic          wr_ready;
    logic          tx_ready = 1'b0;
    logic          tx_valid;
    logic [DW-1:0] tx_data;
    logic          tx_sop, tx_eop;
    logic [EW-1:0] tx_empty;
    logic          tx_error, tx_skip_crc;

    always #10 clk = ~clk;

    pkt_streamer #(.DATA_W(DW), .EMPTY_W(EW), .DEPTH(DEP), .READY_LAT(LAT)) u0 (
        .clk(clk), .rst(rst), .link_stable(link_stable),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_eop(wr_eop), .wr_empty(wr_empty),
        .wr_error(wr_error), .wr_skip_crc(wr_skip_crc), .wr_ready(wr_ready),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop),
        .tx_eop(tx_eop), .tx_empty(tx_empty), .tx_error(tx_error), .tx_skip_crc(tx_skip_crc)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Expected word queue
    logic [DW-1:0] e_data  [128];
    logic          e_first [128];
    logic          e_eop   [128];
    logic [EW-1:0] e_empty [128];
    logic          e_err   [128];
    logic          e_skip  [128];
    int wr_n = 0;
    int rd_n = 0;
    int xfer_cnt = 0;
    logic cur_skip = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic logic [DW-1:0] mk(input int p, input int w);
        logic [31:0] u;
        u = {8'(p), 8'(w), 16'hA5C3 ^ 16'(p * 7 + w)};
        return {16{u}};
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Port monitor, sampled mid-cycle
    logic [3:0]    rh = '0;
    logic          in_pkt_b = 1'b0;
    logic          held = 1'b0;
    logic [DW-1:0] held_data;
    logic          held_eop;

    always @(negedge clk) begin
        logic allow_b;
        if (rst) begin
            rh = '0; in_pkt_b = 1'b0; held = 1'b0;
        end else begin
            allow_b = rh[LAT-1];
            if (held) begin
                chk(tx_valid && tx_data == held_data && tx_eop == held_eop, "R4 hold",
                    tx_data[63:0], held_data[63:0]);
                held = 1'b0;
            end
            if (in_pkt_b && allow_b && !tx_valid)
                chk(1'b0, "R3 gap inside packet", 64'(tx_valid), 64'd1);
            if (tx_sop && !allow_b) chk(1'b0, "R1 sop off ready cycle", 64'(allow_b), 64'd1);
            if (tx_sop && !link_stable) chk(1'b0, "R2 sop without link", 64'(link_stable), 64'd1);
            if (tx_valid && allow_b) begin
                xfer_cnt++;
                if (rd_n >= wr_n) begin
                    chk(1'b0, "R9 unexpected word", 64'(rd_n), 64'(wr_n));
                end else begin
                    chk(tx_data == e_data[rd_n], "R9 data/order", tx_data[63:0], e_data[rd_n][63:0]);
                    chk(tx_sop == e_first[rd_n] && tx_eop == e_eop[rd_n], "R5 sop/eop",
                        {tx_sop, tx_eop}, {e_first[rd_n], e_eop[rd_n]});
                    chk(tx_empty == e_empty[rd_n] && tx_error == e_err[rd_n], "R6 empty/error",
                        {tx_empty, tx_error}, {e_empty[rd_n], e_err[rd_n]});
                    chk(tx_skip_crc == e_skip[rd_n], "R7 skip", 64'(tx_skip_crc), 64'(e_skip[rd_n]));
                    rd_n++;
                end
                if (tx_eop) in_pkt_b = 1'b0;
                else if (tx_sop) in_pkt_b = 1'b1;
            end else if (tx_valid) begin
                held = 1'b1; held_data = tx_data; held_eop = tx_eop;
            end
            rh = {rh[2:0], tx_ready};
        end
    end

    task automatic wr_word(input logic [DW-1:0] d, input bit last, input logic [EW-1:0] emp,
                           input bit err, input bit skip, input bit first);
        bit acc;
        wr_valid = 1'b1; wr_data = d; wr_eop = last; wr_empty = emp;
        wr_error = err; wr_skip_crc = skip;
        @(negedge clk);
        acc = wr_ready;
        if (acc) begin
            if (first) cur_skip = skip;
            e_data[wr_n]  = d;
            e_first[wr_n] = first;
            e_eop[wr_n]   = last;
            e_empty[wr_n] = last ? emp : '0;
            e_err[wr_n]   = last ? err : 1'b0;
            e_skip[wr_n]  = cur_skip;
            wr_n++;
        end
        @(posedge clk); #2;
        wr_valid = 1'b0;
    endtask

    // Non-final words carry junk tail fields and a flipped skip to test masking
    task automatic wr_pkt(input int p, input int n, input logic [EW-1:0] emp, input bit err, input bit skip);
        for (int w = 0; w < n; w++) begin
            wr_word(mk(p, w), w == n - 1, (w == n - 1) ? emp : 6'h2A,
                    (w == n - 1) ? err : 1'b1, (w == 0) ? skip : !skip, w == 0);
        end
    endtask

    task automatic drain(input logic [15:0] pat, input int maxc);
        for (int c = 0; c < maxc; c++) begin
            if (rd_n == wr_n && !in_pkt_b) break;
            tx_ready = pat[c % 16];
            step(1);
        end
        tx_ready = 1'b0;
        step(LAT + 2);
        chk(rd_n == wr_n, "R3 all words delivered", 64'(rd_n), 64'(wr_n));
    endtask

    initial begin
        #3000000;
        chk(1'b0, "watchdog expired", 64'(rd_n), 64'(wr_n));
        report();
    end

    initial begin
        int x0;
        step(4);
        rst = 1'b0;
        step(1);
        // R11 reset state
        chk(!tx_valid && !tx_sop, "R11 outputs idle after reset", {tx_valid, tx_sop}, 64'd0);
        chk(wr_ready, "R11 buffer empty after reset", 64'(wr_ready), 64'd1);

        // R2: packet held while link is not stable
        wr_pkt(50, 2, 6'd3, 1'b0, 1'b0);
        tx_ready = 1'b1;
        step(10);
        chk(xfer_cnt == 0 && !tx_valid, "R2 no start without link", 64'(xfer_cnt), 64'd0);
        link_stable = 1'b1;
        drain(16'hFFFF, 100);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            tx_ready = 1'b0;
            wr_pkt(v, int'(VEC[v][3:0]), VEC[v][9:4], VEC[v][10], VEC[v][11]);
            drain(VEC[v][31:16], 400);
        end

        // R8: nothing leaves until the last word is written
        tx_ready = 1'b1;
        x0 = xfer_cnt;
        wr_word(mk(60, 0), 1'b0, 6'h2A, 1'b1, 1'b1, 1'b1);
        step(4);
        wr_word(mk(60, 1), 1'b0, 6'h2A, 1'b1, 1'b0, 1'b0);
        step(4);
        chk(xfer_cnt == x0 && !tx_valid, "R8 held until eop written", 64'(xfer_cnt - x0), 64'd0);
        wr_word(mk(60, 2), 1'b1, 6'd9, 1'b0, 1'b0, 1'b0);
        drain(16'hFFFF, 100);
        chk(xfer_cnt - x0 == 3, "R8 packet sent after eop", 64'(xfer_cnt - x0), 64'd3);

        // R1: one ready cycle gives one transfer, LAT cycles later
        tx_ready = 1'b0;
        wr_pkt(70, 8, 6'd11, 1'b0, 1'b1);
        step(2);
        x0 = xfer_cnt;
        tx_ready = 1'b1; step(1); tx_ready = 1'b0; step(6);
        chk(xfer_cnt - x0 == 1, "R1 single ready pulse", 64'(xfer_cnt - x0), 64'd1);
        tx_ready = 1'b1; step(3); tx_ready = 1'b0; step(6);
        chk(xfer_cnt - x0 == 4, "R1 stop exactly after latency", 64'(xfer_cnt - x0), 64'd4);
        drain(16'hFFFF, 100);

        // R10: full buffer refuses writes
        tx_ready = 1'b0;
        wr_pkt(80, 8, 6'd2, 1'b1, 1'b0);
        wr_pkt(81, 8, 6'd0, 1'b0, 1'b1);
        chk(!wr_ready, "R10 full at DEPTH words", 64'(wr_ready), 64'd0);
        x0 = wr_n;
        wr_word(mk(99, 0), 1'b1, 6'd0, 1'b0, 1'b0, 1'b1);
        chk(wr_n == x0 && !wr_ready, "R10 write while full dropped", 64'(wr_n - x0), 64'd0);
        x0 = xfer_cnt;
        drain(16'hFFFF, 200);
        step(8);
        chk(xfer_cnt - x0 == 16, "R10 only buffered words leave", 64'(xfer_cnt - x0), 64'd16);
        chk(wr_ready, "R10 room after drain", 64'(wr_ready), 64'd1);

        report();
    end
endmodule